// File: doc/BRIEF.md
# Dual-Rail Precharge Substitution Datapath

This block models a key-mixed byte substitution built in wave-style dual-rail precharge logic. Every logical bit travels as a pair of wires, a true rail and a false rail. A phase signal alternates between a precharge half and an evaluate half on every clock edge. In precharge both rails of every pair are held low. In evaluate exactly one rail of each pair rises. As a result every gate output makes exactly one rising transition per precharge/evaluate pair, whatever the data.

Stimulus comes from an internal 8-bit maximal-length LFSR, which steps once per evaluate half. The stimulus byte is XOR-mixed with a key byte sampled from the ports. The result passes through a nonlinear substitution made only of non-inverting AND/OR networks. Inversion is done by exchanging rails, so the precharge zeros flow through untouched.

An optional mirrored copy of the network can be built. It takes rail-swapped inputs and uses the dual gate in every position. Its rails are therefore the exchange of the main rails, which evens out the switching between the two wires of each pair.

Top module: `dr_subst_core`

## Requirements
- R1: While reset is asserted, `eval_o` is 0, all eight output pairs of both copies read (0,0), and `stim_o` holds the seed value 0x01.
- R2: After reset is released, the phase starts in precharge. The first evaluate half begins within six clock edges. From then on `eval_o` toggles on every rising clock edge.
- R3: During every precharge half (`eval_o`=0), every true and false output rail of both copies is 0.
- R4: During every evaluate half (`eval_o`=1), exactly one rail of each output pair is 1, so `out_t_o` XOR `out_f_o` is all ones.
- R5: During evaluate, `out_t_o` equals S(m), where m = `stim_o` XOR key and S(m) = rotl(m,1) XOR (m AND rotl(m,2)) XOR 0x63. Here rotl rotates left toward the MSB.
- R6: The key is sampled only on the edge that enters evaluate. A change of `key_i` during an evaluate half leaves the outputs of that half unchanged. A key set during precharge is the one used in the following evaluate half.
- R7: `stim_o` is constant through each evaluate half. It steps on the edge that leaves evaluate, to {s[6:0], s[7]^s[5]^s[4]^s[3]} (polynomial x^8+x^6+x^5+x^4+1). It returns to its starting value after exactly 255 evaluate halves.
- R8: With the mirror copy built (default), `mir_t_o` equals `out_f_o` and `mir_f_o` equals `out_t_o` in both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every rising edge flips the phase |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| key_i | input | 8 | Key byte, sampled on the edge entering evaluate |
| eval_o | output | 1 | 1 in the evaluate half, 0 in precharge |
| stim_o | output | 8 | Current LFSR stimulus byte |
| out_t_o | output | 8 | True rails of the substituted byte |
| out_f_o | output | 8 | False rails of the substituted byte |
| mir_t_o | output | 8 | True rails of the mirrored copy |
| mir_f_o | output | 8 | False rails of the mirrored copy |

## Verification
The stimulus is generated inside the block, so reaching all 256 substitution inputs from the ports is the difficult part. An LFSR alone never produces zero and follows a fixed order. The bench therefore keeps its own model of the LFSR sequence. Before each evaluate half it sets the key to the wanted mixed value XOR the stimulus that is about to appear, which walks the mixed value through 0 to 255 in order. The sampling edge of the key is also exercised: the key is changed in the middle of an evaluate half and again during precharge.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_XOR  = 2'd2,
    OP_XNOR = 2'd3
  } gate_op_e;

  function automatic gate_op_e dual_op(input gate_op_e op);
    case (op)
      OP_AND:  return OP_OR;
      OP_OR:   return OP_AND;
      OP_XOR:  return OP_XNOR;
      default: return OP_XOR;
    endcase
  endfunction
endpackage

// File: rtl/dr_gate.sv
// Dual-rail positive gate. MIRROR selects the De Morgan dual, used when the
// inputs arrive with exchanged rails so the output comes out exchanged too.
module dr_gate
  import dr_pkg::*;
#(
  parameter gate_op_e OP     = OP_AND,
  parameter bit       MIRROR = 1'b0
) (
  input  rail_t a_i,
  input  rail_t b_i,
  output rail_t y_o
);
  localparam gate_op_e EFF = MIRROR ? dual_op(OP) : OP;

  generate
    if (EFF == OP_AND) begin : g_and
      assign y_o.t = a_i.t & b_i.t;
      assign y_o.f = a_i.f | b_i.f;
    end else if (EFF == OP_OR) begin : g_or
      assign y_o.t = a_i.t | b_i.t;
      assign y_o.f = a_i.f & b_i.f;
    end else if (EFF == OP_XOR) begin : g_xor
      assign y_o.t = (a_i.t & b_i.f) | (a_i.f & b_i.t);
      assign y_o.f = (a_i.t & b_i.t) | (a_i.f & b_i.f);
    end else begin : g_xnor
      assign y_o.t = (a_i.t & b_i.t) | (a_i.f & b_i.f);
      assign y_o.f = (a_i.t & b_i.f) | (a_i.f & b_i.t);
    end
  endgenerate
endmodule

// File: rtl/dr_subst_net.sv
// Key mixing followed by the substitution, entirely in dual-rail gates.
module dr_subst_net
  import dr_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter logic [W-1:0] CONST = 8'h63,
  parameter bit          MIRROR = 1'b0
) (
  input  rail_t [W-1:0] d_i,
  input  rail_t [W-1:0] k_i,
  output rail_t [W-1:0] y_o
);
  rail_t [W-1:0] mix;
  rail_t [W-1:0] prod;
  rail_t [W-1:0] sum;

  generate
    for (genvar i = 0; i < W; i++) begin : g_mix
      dr_gate #(.OP(OP_XOR), .MIRROR(MIRROR)) u_mix (
        .a_i(d_i[i]), .b_i(k_i[i]), .y_o(mix[i])
      );
    end

    for (genvar i = 0; i < W; i++) begin : g_sub
      localparam int unsigned R1I = (i + W - 1) % W;
      localparam int unsigned R2I = (i + W - 2) % W;

      dr_gate #(.OP(OP_AND), .MIRROR(MIRROR)) u_and (
        .a_i(mix[i]), .b_i(mix[R2I]), .y_o(prod[i])
      );
      dr_gate #(.OP(OP_XOR), .MIRROR(MIRROR)) u_xor (
        .a_i(mix[R1I]), .b_i(prod[i]), .y_o(sum[i])
      );

      // A constant one inverts the bit: done by exchanging rails.
      if (CONST[i]) begin : g_inv
        assign y_o[i].t = sum[i].f;
        assign y_o[i].f = sum[i].t;
      end else begin : g_pass
        assign y_o[i] = sum[i];
      end
    end
  endgenerate
endmodule

// File: rtl/dr_lfsr.sv
module dr_lfsr #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_q;
    if (step_i) begin
      q_d = {q_q[W-2:0], ^(q_q & TAPS)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= SEED;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/dr_phase_ctrl.sv
// Phase toggle plus the single-ended to dual-rail boundary registers.
module dr_phase_ctrl
  import dr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  data_i,
  input  logic [W-1:0]  key_i,
  output logic          eval_o,
  output rail_t [W-1:0] d_o,
  output rail_t [W-1:0] k_o
);
  logic          eval_q, eval_d;
  rail_t [W-1:0] d_q, d_d;
  rail_t [W-1:0] k_q, k_d;

  always_comb begin
    eval_d = ~eval_q;
    d_d    = '0;
    k_d    = '0;
    if (!eval_q) begin
      for (int i = 0; i < W; i++) begin
        d_d[i].t = data_i[i];
        d_d[i].f = ~data_i[i];
        k_d[i].t = key_i[i];
        k_d[i].f = ~key_i[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_q <= 1'b0;
      d_q    <= '0;
      k_q    <= '0;
    end else begin
      eval_q <= eval_d;
      d_q    <= d_d;
      k_q    <= k_d;
    end
  end

  assign eval_o = eval_q;
  assign d_o    = d_q;
  assign k_o    = k_q;
endmodule

// File: rtl/dr_subst_core.sv
module dr_subst_core
  import dr_pkg::*;
#(
  parameter int unsigned  W         = 8,
  parameter logic [W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [W-1:0] LFSR_SEED = 8'h01,
  parameter logic [W-1:0] SUB_CONST = 8'h63,
  parameter bit           MIRROR_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] key_i,
  output logic         eval_o,
  output logic [W-1:0] stim_o,
  output logic [W-1:0] out_t_o,
  output logic [W-1:0] out_f_o,
  output logic [W-1:0] mir_t_o,
  output logic [W-1:0] mir_f_o
);
  logic          sync_q;
  logic          rst_sync_n;
  logic          eval;
  logic [W-1:0]  stim;
  rail_t [W-1:0] d_r, k_r, y_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      sync_q     <= 1'b1;
      rst_sync_n <= sync_q;
    end
  end

  dr_lfsr #(.W(W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_sync_n), .step_i(eval), .q_o(stim)
  );

  dr_phase_ctrl #(.W(W)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .data_i(stim), .key_i(key_i),
    .eval_o(eval), .d_o(d_r), .k_o(k_r)
  );

  dr_subst_net #(.W(W), .CONST(SUB_CONST), .MIRROR(1'b0)) u_net (
    .d_i(d_r), .k_i(k_r), .y_o(y_r)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_out
      assign out_t_o[i] = y_r[i].t;
      assign out_f_o[i] = y_r[i].f;
    end

    if (MIRROR_EN) begin : g_mirror
      rail_t [W-1:0] md_r, mk_r, my_r;
      for (genvar i = 0; i < W; i++) begin : g_swap
        assign md_r[i].t = d_r[i].f;
        assign md_r[i].f = d_r[i].t;
        assign mk_r[i].t = k_r[i].f;
        assign mk_r[i].f = k_r[i].t;
        assign mir_t_o[i] = my_r[i].t;
        assign mir_f_o[i] = my_r[i].f;
      end
      dr_subst_net #(.W(W), .CONST(SUB_CONST), .MIRROR(1'b1)) u_mnet (
        .d_i(md_r), .k_i(mk_r), .y_o(my_r)
      );
    end else begin : g_nomirror
      assign mir_t_o = '0;
      assign mir_f_o = '0;
    end
  endgenerate

  assign eval_o = eval;
  assign stim_o = stim;
endmodule

// File: rtl/dr_subst_core_chk.sv
module dr_subst_core_chk #(
  parameter int unsigned W         = 8,
  parameter bit          MIRROR_EN = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         eval,
  input logic [W-1:0] stim,
  input logic [W-1:0] out_t,
  input logic [W-1:0] out_f,
  input logic [W-1:0] mir_t,
  input logic [W-1:0] mir_f
);
  // R2
  pre_to_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> eval);

  // R2
  eval_to_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval |=> !eval);

  // R3
  pre_rails_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |-> (out_t == '0 && out_f == '0 && mir_t == '0 && mir_f == '0));

  // R4
  eval_one_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval |-> ((out_t ^ out_f) == {W{1'b1}}));

  // R7
  stim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval |-> $stable(stim));

  // R7
  stim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval |=> (stim != $past(stim)));

  generate
    if (MIRROR_EN) begin : g_mir
      // R8
      mirror_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_t == out_f && mir_f == out_t));
    end
  endgenerate
endmodule

bind dr_subst_core dr_subst_core_chk #(.W(W), .MIRROR_EN(MIRROR_EN)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .eval(eval_o), .stim(stim_o),
  .out_t(out_t_o), .out_f(out_f_o), .mir_t(mir_t_o), .mir_f(mir_f_o)
);

// File: tb/dr_subst_core_tb.sv
module dr_subst_core_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic [7:0] key_i;
  logic       eval_o;
  logic [7:0] stim_o, out_t_o, out_f_o, mir_t_o, mir_f_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_s;

  dr_subst_core u_dut (
    .clk(clk), .rst_n(rst_n), .key_i(key_i), .eval_o(eval_o),
    .stim_o(stim_o), .out_t_o(out_t_o), .out_f_o(out_f_o),
    .mir_t_o(mir_t_o), .mir_f_o(mir_f_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] lfsr_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] subst(input logic [7:0] m);
    logic [7:0] r1, r2;
    r1 = {m[6:0], m[7]};
    r2 = {m[5:0], m[7:6]};
    return r1 ^ (m & r2) ^ 8'h63;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // From an evaluate half, set the key for the next one and move there,
  // checking the precharge half in between.
  task automatic step_eval(input logic [7:0] next_key);
    key_i = next_key;
    @(negedge clk);
    chk(eval_o == 1'b0, "R2 phase low", {31'd0, eval_o}, 0);
    chk(out_t_o == 0 && out_f_o == 0 && mir_t_o == 0 && mir_f_o == 0,
        "R3 precharge zero", {out_t_o, out_f_o, mir_t_o, mir_f_o}, 0);
    @(negedge clk);
    chk(eval_o == 1'b1, "R2 phase high", {31'd0, eval_o}, 1);
    exp_s = lfsr_next(exp_s);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    key_i = 8'h00;
    repeat (3) @(negedge clk);
    chk(eval_o == 1'b0, "R1 phase", {31'd0, eval_o}, 0);
    chk(out_t_o == 0 && out_f_o == 0 && mir_t_o == 0 && mir_f_o == 0,
        "R1 rails", {out_t_o, out_f_o, mir_t_o, mir_f_o}, 0);
    chk(stim_o == 8'h01, "R1 seed", stim_o, 8'h01);
  endtask

  task automatic t_start();
    int n = 0;
    rst_n = 1'b1;
    while (!eval_o && n < 6) begin
      @(negedge clk);
      n++;
    end
    chk(eval_o == 1'b1, "R2 first evaluate", {31'd0, eval_o}, 1);
    exp_s = 8'h01;
    chk(stim_o == exp_s, "R7 first stim", stim_o, exp_s);
    chk(out_t_o == subst(exp_s), "R5 first output", out_t_o, subst(exp_s));
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 256; v++) begin
      step_eval(8'(v) ^ lfsr_next(exp_s));
      chk(stim_o == exp_s, "R7 stim order", stim_o, exp_s);
      chk(out_t_o == subst(8'(v)), "R5 substitution", out_t_o, subst(8'(v)));
      chk((out_t_o ^ out_f_o) == 8'hFF, "R4 one rail", out_t_o ^ out_f_o, 8'hFF);
      chk(mir_t_o == out_f_o && mir_f_o == out_t_o, "R8 mirror",
          {mir_t_o, mir_f_o}, {out_f_o, out_t_o});
    end
  endtask

  task automatic t_key_hold();
    logic [7:0] held_t, held_f;
    logic [7:0] k2;
    step_eval(8'h5A);
    held_t = out_t_o;
    held_f = out_f_o;
    chk(held_t == subst(exp_s ^ 8'h5A), "R6 sampled key", held_t,
        subst(exp_s ^ 8'h5A));
    key_i = 8'hC3;
    #1;
    chk(out_t_o == held_t && out_f_o == held_f, "R6 mid-evaluate key ignored",
        {out_t_o, out_f_o}, {held_t, held_f});
    @(negedge clk);
    k2 = 8'h27;
    key_i = k2;
    @(negedge clk);
    exp_s = lfsr_next(exp_s);
    chk(out_t_o == subst(exp_s ^ k2), "R6 precharge key used", out_t_o,
        subst(exp_s ^ k2));
  endtask

  task automatic t_period();
    logic [7:0] start;
    int early = 0;
    start = stim_o;
    for (int n = 1; n <= 255; n++) begin
      step_eval(8'h00);
      if (n < 255 && stim_o == start) early++;
    end
    chk(early == 0, "R7 no early repeat", early, 0);
    chk(stim_o == start, "R7 period 255", stim_o, start);
    chk(stim_o == exp_s, "R7 model match", stim_o, exp_s);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_start();
    t_sweep();
    t_key_hold();
    t_period();
    summary();
  end
endmodule